// File: doc/BRIEF.md
# Memory Access Protection Checker

This block holds a small, parameterised set of protection entries and decides, in the same cycle, whether a physical memory access may proceed. Each entry pairs a word-granular address register with an 8-bit configuration byte. Both are written through a single register-style write port and can be read back through a read port. The configuration byte selects how the address register describes a region and which access kinds that region grants. A lock flag in the byte freezes the entry and also applies it to machine-mode accesses.

The check port takes a physical byte address, an access kind (instruction fetch, data load or data store) and the current privilege level. It returns an allow flag and, when the access is refused, the exception cause code. Entries are searched from index 0 upward and the lowest-numbered matching entry alone decides the outcome. The check is purely combinational on the stored entries, so a fetch or load/store unit can use the result in the cycle it presents the address.

Top module: `mem_guard`

## Requirements
- R1: After reset every configuration byte and every address register read back as zero, so all entries are disabled.
- R2: The configuration byte is laid out as bit 7 lock, bits 6:5 reserved, bits 4:3 region mode, bit 2 execute, bit 1 write and bit 0 read. The reserved bits always read back as zero, whatever value is written. A write with `wr_cfg_i`=1 targets the byte (from `wr_data_i[7:0]`) and a write with `wr_cfg_i`=0 targets the address register.
- R3: While an entry's lock bit is set, writes to its configuration byte and to its address register are ignored until reset. Writes to an index at or above the entry count are also ignored.
- R4: In region mode 01 (top-of-range), an entry matches byte addresses from 4 times the previous entry's address register up to, but excluding, 4 times its own. For entry 0 the lower bound is address 0.
- R5: In region mode 10, an entry matches exactly the 4 bytes starting at 4 times its address register.
- R6: In region mode 11, the address register holds (base>>2) | (size/8 - 1) for a power-of-two size of at least 8 bytes. The count of trailing ones k gives a region of 8<<k bytes, and all ones matches every address. Region mode 00 never matches.
- R7: The lowest-numbered matching entry alone decides the result, even when higher entries also match.
- R8: A machine-mode access (`chk_priv_i`=3) ignores a matching entry whose lock bit is clear and is allowed. If the lock bit is set, the access is checked against that entry's permission bits.
- R9: Supervisor (1) and user (0) accesses are allowed only if the matching entry grants the needed permission: execute for a fetch, read for a load, write for a store.
- R10: When no entry matches, a machine-mode access is allowed and a supervisor or user access is denied.
- R11: The access-kind encoding is 0 for a fetch, 1 for a load, and 2 or 3 for a store. A denied access reports cause 1 for a fetch, 5 for a load and 7 for a store, and an allowed access reports cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the entry registers |
| wr_cfg_i | input | 1 | 1 selects the configuration byte, 0 selects the address register |
| wr_idx_i | input | IDX_W (3) | Entry index for the write |
| wr_data_i | input | AR_W (32) | Write data; configuration uses bits 7:0 |
| rd_idx_i | input | IDX_W (3) | Entry index for read-back |
| rd_cfg_o | output | 8 | Configuration byte of the read entry |
| rd_addr_o | output | AR_W (32) | Address register of the read entry |
| chk_addr_i | input | PA_W (34) | Physical byte address under check |
| chk_type_i | input | 2 | Access kind: 0 fetch, 1 load, 2/3 store |
| chk_priv_i | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| chk_allow_o | output | 1 | Access permitted |
| chk_cause_o | output | 4 | Fault cause when denied, 0 when allowed |

## Verification
The hardest situation to reach is several overlapping regions of different modes, where a lower-numbered entry must shadow a wider one that also matches. A secondary difficulty is a locked entry that has to resist later rewrites while still governing machine-mode traffic. Directed steps build a stack of top-of-range, 4-byte and power-of-two entries at hand-picked addresses and then lock one of them. The random phase keeps address registers and check addresses inside a narrow window so that region overlaps and boundary hits come up often. Lock bits are set only rarely in that phase, so the table stays writable for most of the run.

// File: rtl/mg_pkg.sv
package mg_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_TOR   = 2'b01,
    MODE_NA4   = 2'b10,
    MODE_NAPOT = 2'b11
  } amode_e;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] PRIV_M    = 2'd3;

  localparam int unsigned CFG_LOCK = 7;
  localparam int unsigned CFG_X    = 2;
  localparam int unsigned CFG_W    = 1;
  localparam int unsigned CFG_R    = 0;
  localparam logic [7:0]  CFG_WMASK = 8'h9F;

  function automatic logic [3:0] fault_cause(input logic [1:0] acc);
    case (acc)
      ACC_FETCH: return 4'd1;
      ACC_LOAD:  return 4'd5;
      default:   return 4'd7;
    endcase
  endfunction
endpackage

// File: rtl/mg_entry_regs.sv
module mg_entry_regs import mg_pkg::*; #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned AR_W      = 32,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic                           wr_cfg_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [AR_W-1:0]                wr_data_i,
  output logic [N_ENTRIES-1:0][7:0]      cfg_q_o,
  output logic [N_ENTRIES-1:0][AR_W-1:0] addr_q_o
);
  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (int'(wr_idx_i) == i) && !cfg_q_o[i][CFG_LOCK];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q_o[i]  <= '0;
        addr_q_o[i] <= '0;
      end else if (sel) begin
        if (wr_cfg_i) cfg_q_o[i]  <= wr_data_i[7:0] & CFG_WMASK;
        else          addr_q_o[i] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/mg_region_match.sv
module mg_region_match import mg_pkg::*; #(
  parameter int unsigned AR_W = 32
) (
  input  amode_e          mode_i,
  input  logic [AR_W-1:0] word_i,
  input  logic [AR_W-1:0] lo_i,
  input  logic [AR_W-1:0] top_i,
  output logic            hit_o
);
  logic [AR_W-1:0] napot_care;

  // trailing ones plus the zero above them are don't-care bits
  always_comb napot_care = ~(top_i ^ (top_i + 1'b1));

  always_comb begin
    unique case (mode_i)
      MODE_TOR:   hit_o = (word_i >= lo_i) && (word_i < top_i);
      MODE_NA4:   hit_o = (word_i == top_i);
      MODE_NAPOT: hit_o = ((word_i ^ top_i) & napot_care) == '0;
      default:    hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mem_guard.sv
module mem_guard import mg_pkg::*; #(
  parameter  int unsigned N_ENTRIES = 8,
  parameter  int unsigned PA_W      = 34,
  localparam int unsigned AR_W      = PA_W - 2,
  localparam int unsigned IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_cfg_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [AR_W-1:0]  wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_cfg_o,
  output logic [AR_W-1:0]  rd_addr_o,
  input  logic [PA_W-1:0]  chk_addr_i,
  input  logic [1:0]       chk_type_i,
  input  logic [1:0]       chk_priv_i,
  output logic             chk_allow_o,
  output logic [3:0]       chk_cause_o
);
  logic [N_ENTRIES-1:0][7:0]      cfg_q;
  logic [N_ENTRIES-1:0][AR_W-1:0] addr_q;
  logic [N_ENTRIES-1:0]           hit;
  logic [AR_W-1:0]                word;
  logic                           unused_lsb;
  logic                           hit_any;
  logic [IDX_W-1:0]               sel;
  logic                           sel_lock;
  logic                           perm_ok;
  logic                           allow;

  assign word       = chk_addr_i[PA_W-1:2];
  assign unused_lsb = ^chk_addr_i[1:0];

  mg_entry_regs #(
    .N_ENTRIES (N_ENTRIES),
    .AR_W      (AR_W),
    .IDX_W     (IDX_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_cfg_i  (wr_cfg_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .cfg_q_o   (cfg_q),
    .addr_q_o  (addr_q)
  );

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_match
    logic [AR_W-1:0] lo;
    if (i == 0) begin : g_first
      assign lo = '0;
    end else begin : g_rest
      assign lo = addr_q[i-1];
    end
    mg_region_match #(.AR_W(AR_W)) u_match (
      .mode_i (amode_e'(cfg_q[i][4:3])),
      .word_i (word),
      .lo_i   (lo),
      .top_i  (addr_q[i]),
      .hit_o  (hit[i])
    );
  end

  // lowest index wins
  always_comb begin
    hit_any = 1'b0;
    sel     = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_any = 1'b1;
        sel     = IDX_W'(i);
      end
    end
  end

  always_comb begin
    sel_lock = cfg_q[sel][CFG_LOCK];
    case (chk_type_i)
      ACC_FETCH: perm_ok = cfg_q[sel][CFG_X];
      ACC_LOAD:  perm_ok = cfg_q[sel][CFG_R];
      default:   perm_ok = cfg_q[sel][CFG_W];
    endcase
    if (!hit_any)                             allow = (chk_priv_i == PRIV_M);
    else if (chk_priv_i == PRIV_M && !sel_lock) allow = 1'b1;
    else                                      allow = perm_ok;
  end

  assign chk_allow_o = allow;
  assign chk_cause_o = allow ? 4'd0 : fault_cause(chk_type_i);

  always_comb begin
    if (int'(rd_idx_i) < N_ENTRIES) begin
      rd_cfg_o  = cfg_q[rd_idx_i];
      rd_addr_o = addr_q[rd_idx_i];
    end else begin
      rd_cfg_o  = '0;
      rd_addr_o = '0;
    end
  end
endmodule

// File: rtl/mem_guard_chk.sv
module mem_guard_chk #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned AR_W      = 32
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [N_ENTRIES-1:0][7:0]      cfg_q,
  input logic [N_ENTRIES-1:0][AR_W-1:0] addr_q,
  input logic [1:0]                     chk_type_i,
  input logic [1:0]                     chk_priv_i,
  input logic                           chk_allow_o,
  input logic [3:0]                     chk_cause_o
);
  logic any_on;
  logic [3:0] want_cause;

  always_comb begin
    any_on = 1'b0;
    for (int i = 0; i < N_ENTRIES; i++) any_on |= (cfg_q[i][4:3] != 2'b00);
  end

  assign want_cause = (chk_type_i == 2'd0) ? 4'd1 : (chk_type_i == 2'd1) ? 4'd5 : 4'd7;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q[i][6:5] == 2'b00);                                           // R2
    AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q[i][7] |=> $stable(cfg_q[i]) && $stable(addr_q[i]));          // R3
  end

  AST_ALLOW_NO_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_allow_o |-> chk_cause_o == 4'd0);                                // R11
  AST_DENY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_allow_o |-> chk_cause_o == want_cause);                         // R11
  AST_EMPTY_M_ALLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_on && chk_priv_i == 2'd3) |-> chk_allow_o);                    // R10
  AST_EMPTY_SU_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_on && chk_priv_i != 2'd3) |-> !chk_allow_o);                   // R10
endmodule

bind mem_guard mem_guard_chk #(
  .N_ENTRIES (N_ENTRIES),
  .AR_W      (AR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_q       (cfg_q),
  .addr_q      (addr_q),
  .chk_type_i  (chk_type_i),
  .chk_priv_i  (chk_priv_i),
  .chk_allow_o (chk_allow_o),
  .chk_cause_o (chk_cause_o)
);

// File: tb/mem_guard_tb_top.sv
module mem_guard_tb_top;
  localparam int N    = 8;
  localparam int PA_W = 34;
  localparam int AR_W = PA_W - 2;
  localparam int IW   = 3;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            wr_en_i = 1'b0, wr_cfg_i = 1'b0;
  logic [IW-1:0]   wr_idx_i = '0, rd_idx_i = '0;
  logic [AR_W-1:0] wr_data_i = '0;
  logic [7:0]      rd_cfg_o;
  logic [AR_W-1:0] rd_addr_o;
  logic [PA_W-1:0] chk_addr_i = '0;
  logic [1:0]      chk_type_i = '0, chk_priv_i = '0;
  logic            chk_allow_o;
  logic [3:0]      chk_cause_o;

  int errors = 0;
  int checks = 0;

  logic [7:0]      m_cfg  [N];
  logic [AR_W-1:0] m_addr [N];

  always #2 clk = ~clk;

  mem_guard #(.N_ENTRIES(N), .PA_W(PA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_cfg_i(wr_cfg_i),
    .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .rd_idx_i(rd_idx_i),
    .rd_cfg_o(rd_cfg_o), .rd_addr_o(rd_addr_o), .chk_addr_i(chk_addr_i),
    .chk_type_i(chk_type_i), .chk_priv_i(chk_priv_i),
    .chk_allow_o(chk_allow_o), .chk_cause_o(chk_cause_o)
  );

  function automatic logic ent_hit(int i, longint unsigned w);
    longint unsigned a, lo, span, base;
    int k;
    a = longint'(m_addr[i]);
    case (m_cfg[i][4:3])
      2'b01: begin
        lo = (i == 0) ? 0 : longint'(m_addr[i-1]);
        return (w >= lo) && (w < a);
      end
      2'b10: return w == a;
      2'b11: begin
        k = 0;
        while (k < AR_W && a[k]) k++;
        if (k >= AR_W) return 1'b1;
        span = 64'd2 << k;              // words in region of 8<<k bytes
        base = a & ~(span - 1);
        return (w >= base) && (w < base + span);
      end
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [4:0] model(longint unsigned addr, logic [1:0] t, logic [1:0] p);
    logic ok;
    logic [3:0] c;
    int f;
    f = -1;
    for (int i = N - 1; i >= 0; i--) if (ent_hit(i, addr >> 2)) f = i;
    if (f < 0) ok = (p == 2'd3);
    else if (p == 2'd3 && !m_cfg[f][7]) ok = 1'b1;
    else ok = (t == 2'd0) ? m_cfg[f][2] : (t == 2'd1) ? m_cfg[f][0] : m_cfg[f][1];
    c = ok ? 4'd0 : (t == 2'd0) ? 4'd1 : (t == 2'd1) ? 4'd5 : 4'd7;
    return {ok, c};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    for (int i = 0; i < N; i++) begin m_cfg[i] = '0; m_addr[i] = '0; end
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input bit is_cfg, input int idx, input logic [AR_W-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_cfg_i = is_cfg; wr_idx_i = IW'(idx); wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (idx < N && !m_cfg[idx][7]) begin
      if (is_cfg) m_cfg[idx] = d[7:0] & 8'h9F;
      else        m_addr[idx] = d;
    end
  endtask

  task automatic chk(input longint unsigned a, input logic [1:0] t, input logic [1:0] p,
                     input string tag);
    logic [4:0] e;
    @(negedge clk);
    chk_addr_i = PA_W'(a); chk_type_i = t; chk_priv_i = p;
    #1;
    e = model(a, t, p);
    checks++;
    if ({chk_allow_o, chk_cause_o} !== e) begin
      errors++;
      $display("FAIL %s addr=%h type=%0d priv=%0d: allow/cause=%b/%0d expected %b/%0d",
               tag, a, t, p, chk_allow_o, chk_cause_o, e[4], e[3:0]);
    end
  endtask

  task automatic rb(input int idx, input string tag);
    @(negedge clk);
    rd_idx_i = IW'(idx);
    #1;
    checks++;
    if (rd_cfg_o !== m_cfg[idx] || rd_addr_o !== m_addr[idx]) begin
      errors++;
      $display("FAIL %s idx=%0d: cfg=%h addr=%h expected cfg=%h addr=%h",
               tag, idx, rd_cfg_o, rd_addr_o, m_cfg[idx], m_addr[idx]);
    end
  endtask

  task automatic expect_fixed(input logic a, input logic [3:0] c, input string tag);
    checks++;
    if (chk_allow_o !== a || chk_cause_o !== c) begin
      errors++;
      $display("FAIL %s: allow/cause=%b/%0d expected %b/%0d", tag, chk_allow_o, chk_cause_o, a, c);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    do_reset();
    // R1 R10 R11: empty table
    for (int i = 0; i < N; i++) rb(i, "R1 reset readback");
    chk(64'h100, 2'd1, 2'd3, "R10 empty M load");
    expect_fixed(1'b1, 4'd0, "R10 empty M load fixed");
    chk(64'h100, 2'd1, 2'd1, "R10 empty S load");
    expect_fixed(1'b0, 4'd5, "R11 empty S load cause");
    chk(64'h0, 2'd0, 2'd0, "R11 empty U fetch");
    expect_fixed(1'b0, 4'd1, "R11 fetch cause");

    // R2 R4: entry 0 TOR [0,0x1000) RW, reserved bits written
    wr(1'b1, 0, 32'h6B);
    wr(1'b0, 0, 32'h400);
    rb(0, "R2 reserved bits zero");
    chk(64'hFFC,  2'd1, 2'd1, "R4 TOR top word inside");
    expect_fixed(1'b1, 4'd0, "R4 TOR inside fixed");
    chk(64'h1000, 2'd1, 2'd1, "R4 TOR upper bound excluded");
    expect_fixed(1'b0, 4'd5, "R4 TOR excluded fixed");
    chk(64'h0,    2'd0, 2'd1, "R9 no execute");
    chk(64'h0,    2'd2, 2'd0, "R9 write granted");

    // R4 R7: entry 1 TOR [0x1000,0x2000) X only
    wr(1'b1, 1, 32'h0C);
    wr(1'b0, 1, 32'h800);
    chk(64'h1000, 2'd0, 2'd1, "R4 TOR lower bound prev");
    chk(64'h1FFC, 2'd0, 2'd1, "R4 TOR last word");
    chk(64'hFFC,  2'd0, 2'd1, "R7 entry0 shadows");
    expect_fixed(1'b0, 4'd1, "R7 shadow fixed");
    chk(64'h2000, 2'd0, 2'd1, "R10 past all regions");

    // R5: entry 2 NA4 at 0x4000, read only
    wr(1'b1, 2, 32'h11);
    wr(1'b0, 2, 32'h1000);
    chk(64'h4000, 2'd1, 2'd0, "R5 NA4 hit");
    expect_fixed(1'b1, 4'd0, "R5 NA4 hit fixed");
    chk(64'h4004, 2'd1, 2'd0, "R5 NA4 next word");
    chk(64'h3FFC, 2'd1, 2'd0, "R5 NA4 prev word");
    chk(64'h4000, 2'd2, 2'd0, "R11 store cause");
    expect_fixed(1'b0, 4'd7, "R11 store cause fixed");

    // R6: entry 3 NAPOT 64 bytes at 0x8000, write only
    wr(1'b1, 3, 32'h1A);
    wr(1'b0, 3, 32'h2007);
    chk(64'h803C, 2'd2, 2'd1, "R6 NAPOT last word");
    expect_fixed(1'b1, 4'd0, "R6 NAPOT fixed");
    chk(64'h8040, 2'd2, 2'd1, "R6 NAPOT beyond");
    chk(64'h7FFC, 2'd2, 2'd1, "R6 NAPOT below");
    chk(64'h8000, 2'd1, 2'd1, "R6 NAPOT no read");

    // R8: unlocked entry ignored for M, locked enforced
    chk(64'h0, 2'd0, 2'd3, "R8 M ignores unlocked");
    expect_fixed(1'b1, 4'd0, "R8 M unlocked fixed");
    wr(1'b1, 2, 32'h91);
    chk(64'h4000, 2'd2, 2'd3, "R8 M locked store");
    expect_fixed(1'b0, 4'd7, "R8 M locked fixed");
    chk(64'h4000, 2'd1, 2'd3, "R8 M locked load");
    // R3: locked entry frozen
    wr(1'b1, 2, 32'h00);
    wr(1'b0, 2, 32'h0);
    rb(2, "R3 locked frozen");
    chk(64'h4000, 2'd2, 2'd3, "R3 lock still enforced");
    expect_fixed(1'b0, 4'd7, "R3 lock enforced fixed");

    // R6: all-ones NAPOT matches everything
    wr(1'b0, 4, 32'hFFFF_FFFF);
    wr(1'b1, 4, 32'h1C);
    chk(64'h3_0000_0000, 2'd0, 2'd0, "R6 all-ones NAPOT");
    expect_fixed(1'b1, 4'd0, "R6 all-ones fixed");

    // random phase
    do_reset();
    rb(2, "R1 lock cleared by reset");
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 3) begin
        logic [7:0] c;
        c = 8'($urandom());
        if ($urandom_range(0, 15) != 0) c[7] = 1'b0;
        if ($urandom_range(0, 1) == 1) wr(1'b1, int'($urandom_range(0, N - 1)), {24'h0, c});
        else wr(1'b0, int'($urandom_range(0, N - 1)),
                32'($urandom_range(0, 1023)) | (($urandom_range(0, 7) == 0) ? 32'hFFFF_FFFF : 32'h0));
      end else if (op == 3) begin
        rb(int'($urandom_range(0, N - 1)), "R2 R3 random readback");
      end else begin
        chk(64'($urandom_range(0, 4095)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)) | 2'd0,
            "R7 R9 random check");
      end
      if (n == 750) do_reset();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule